// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a single-cycle write request into a correctly ordered strobe sequence for a 32K x 8 asynchronous static RAM. The user side presents a 15-bit address, a data byte, a style select and a flag saying whether the memory's output enable is to be held active during the write. The block captures all of these when it accepts the request and raises `busy_o`. It then walks the memory through five phases: address setup, leading strobe, write window, data hold and recovery. When the sequence is over it returns to idle with a one-cycle `done_o` pulse.

Two write styles are offered. In the write-enable style, chip enable falls first and write enable marks the write window. In the chip-enable style, write enable falls first and chip enable marks the window. Every timing interval is a parameter in clock cycles. When output enable is held low in the write-enable style, the memory drives the bus until write enable falls. For that case the window is stretched and the data drive is delayed, so the memory's drivers can release the bus before the controller drives data.

All memory-side outputs come directly from flip-flops.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is applied and after it is released, `sram_ce_n_o`, `sram_we_n_o` and `sram_oe_n_o` are 1, and `sram_dq_oe_o`, `busy_o` and `done_o` are 0 until a request arrives.
- R2: A request is taken only when idle. Address, data, style and OE flag are captured at that edge, and `busy_o` is 1 from the next cycle until the sequence ends. A request raised while busy is ignored and never produces a write or a `done_o`.
- R3: `sram_addr_o` changes only between two samples in which both `sram_ce_n_o` and `sram_we_n_o` are 1.
- R4: The style is encoded in `mode_i` as 0 for write-enable style and 1 for chip-enable style. In style 0, `sram_ce_n_o` is low in the cycle before `sram_we_n_o` falls. In style 1, `sram_we_n_o` is low in the cycle before `sram_ce_n_o` falls. Both strobes rise together at the end of the window.
- R5: The window (both strobes low) lasts PB = max(T_WP, T_CW, T_DW, T_AW-T_AS-T_LEAD) cycles. In style 0 with `oe_low_i`=1 it lasts max(PB, T_WHZ+T_DW+1) cycles.
- R6: The data drive turns on T_WHZ cycles after the window opens in style 0 with `oe_low_i`=1, and in the first window cycle otherwise. It is never on while chip enable is low, write enable is high and output enable is low.
- R7: After the window closes, the data stays driven for T_DH cycles with both strobes high. The address then stays unchanged through the T_WR recovery cycles.
- R8: If a request is taken at edge n, `done_o` is 1 for exactly the one cycle after edge n+T_AS+T_LEAD+window+T_DH+T_WR. `busy_o` is 0 in that cycle.
- R9: `sram_oe_n_o` equals the inverse of the captured `oe_low_i` throughout the busy cycles, and is 1 when idle.
- R10: The byte on `sram_dq_o` in the last window cycle equals the captured data, and `sram_addr_o` equals the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, sampled when idle |
| mode_i | input | 1 | 0: write-enable style, 1: chip-enable style |
| oe_low_i | input | 1 | Hold memory output enable active during the write |
| addr_i | input | 15 | Write address |
| data_i | input | 8 | Write byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sram_addr_o | output | 15 | Memory address |
| sram_ce_n_o | output | 1 | Memory chip enable, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_dq_o | output | 8 | Data to memory |
| sram_dq_oe_o | output | 1 | Data drive enable |

## Verification
Each result has a fixed due cycle counted from the accepting edge. `busy_o` is due one cycle later. The window opens T_AS+T_LEAD cycles after that. `done_o` is due exactly after the sum of all phase lengths, with the window length taken from the R5 formula computed in the bench. The bench samples on the falling edge and counts cycles from its own request edge. It compares each count with these arithmetic expectations rather than waiting open-endedly. A monitor model of the memory measures the window length, the drive offset and the hold length against the same numbers, and records the stored byte at the moment the window closes.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LEAD,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } phase_e;

    typedef enum logic {
        WR_BY_WE = 1'b0,
        WR_BY_CE = 1'b1
    } wr_style_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> (load_val_i != '0)); // R8

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int T_AS   = 1,
    parameter int T_LEAD = 1,
    parameter int T_DH   = 1,
    parameter int T_WR   = 1,
    parameter int T_WHZ  = 1,
    parameter int P_BASE = 2,
    parameter int P_TURN = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic              oe_low_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              last_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_ce_n_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o
);
    localparam logic [CNT_W-1:0] DRIVE_AT = CNT_W'(P_TURN - T_WHZ + 1);

    typedef struct packed {
        phase_e            phase;
        wr_style_e         mode;
        logic              turn;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    s_d.phase  = PH_SETUP;
                    s_d.addr   = addr_i;
                    s_d.data   = data_i;
                    s_d.mode   = wr_style_e'(mode_i);
                    s_d.turn   = (mode_i == WR_BY_WE) && oe_low_i;
                    s_d.oe_n   = !oe_low_i;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_AS);
                end
            end
            PH_SETUP: begin
                if (last_i) begin
                    s_d.phase = PH_LEAD;
                    if (s_q.mode == WR_BY_WE) s_d.ce_n = 1'b0;
                    else                      s_d.we_n = 1'b0;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_LEAD);
                end
            end
            PH_LEAD: begin
                if (last_i) begin
                    s_d.phase  = PH_STROBE;
                    s_d.ce_n   = 1'b0;
                    s_d.we_n   = 1'b0;
                    s_d.dq_oe  = !s_q.turn;
                    load_o     = 1'b1;
                    load_val_o = s_q.turn ? CNT_W'(P_TURN) : CNT_W'(P_BASE);
                end
            end
            PH_STROBE: begin
                if (s_q.turn && cnt_i == DRIVE_AT) s_d.dq_oe = 1'b1;
                if (last_i) begin
                    s_d.phase  = PH_HOLD;
                    s_d.ce_n   = 1'b1;
                    s_d.we_n   = 1'b1;
                    s_d.dq_oe  = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_DH);
                end
            end
            PH_HOLD: begin
                if (last_i) begin
                    s_d.phase  = PH_RECOVER;
                    s_d.dq_oe  = 1'b0;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_WR);
                end
            end
            PH_RECOVER: begin
                if (last_i) begin
                    s_d.phase = PH_IDLE;
                    s_d.oe_n  = 1'b1;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.mode  <= WR_BY_WE;
            s_q.ce_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.phase != PH_IDLE);
    assign done_o       = s_q.done;
    assign sram_addr_o  = s_q.addr;
    assign sram_ce_n_o  = s_q.ce_n;
    assign sram_we_n_o  = s_q.we_n;
    assign sram_oe_n_o  = s_q.oe_n;
    assign sram_dq_o    = s_q.data;
    assign sram_dq_oe_o = s_q.dq_oe;

    AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.addr) |-> (s_q.ce_n && s_q.we_n && $past(s_q.ce_n) && $past(s_q.we_n))); // R3

    AST_WE_STYLE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(s_q.we_n) && s_q.mode == WR_BY_WE) |-> !$past(s_q.ce_n)); // R4

    AST_CE_STYLE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(s_q.ce_n) && s_q.mode == WR_BY_CE) |-> !$past(s_q.we_n)); // R4

    AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.dq_oe |-> !(!s_q.ce_n && s_q.we_n && !s_q.oe_n)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.done |=> !s_q.done); // R8

    AST_BUSY_KEEPS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(s_q.data) && $stable(s_q.mode))); // R2

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int T_AS   = 1,
    parameter int T_LEAD = 1,
    parameter int T_WP   = 3,
    parameter int T_CW   = 3,
    parameter int T_AW   = 4,
    parameter int T_DW   = 2,
    parameter int T_DH   = 1,
    parameter int T_WR   = 1,
    parameter int T_WHZ  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic              oe_low_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_ce_n_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o
);
    localparam int P_BASE = imax(imax(T_WP, T_CW), imax(T_DW, T_AW - T_AS - T_LEAD));
    localparam int P_TURN = imax(P_BASE, T_WHZ + T_DW + 1);
    localparam int T_MAX  = imax(imax(imax(T_AS, T_LEAD), imax(T_DH, T_WR)), P_TURN);
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             last;

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .last_o     (last)
    );

    sram_wr_fsm #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W),
        .T_AS   (T_AS),   .T_LEAD (T_LEAD), .T_DH  (T_DH),
        .T_WR   (T_WR),   .T_WHZ  (T_WHZ),
        .P_BASE (P_BASE), .P_TURN (P_TURN)
    ) fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (req_i),
        .mode_i       (mode_i),
        .oe_low_i     (oe_low_i),
        .addr_i       (addr_i),
        .data_i       (data_i),
        .cnt_i        (cnt),
        .last_i       (last),
        .load_o       (load),
        .load_val_o   (load_val),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .sram_addr_o  (sram_addr_o),
        .sram_ce_n_o  (sram_ce_n_o),
        .sram_we_n_o  (sram_we_n_o),
        .sram_oe_n_o  (sram_oe_n_o),
        .sram_dq_o    (sram_dq_o),
        .sram_dq_oe_o (sram_dq_oe_o)
    );

endmodule

// File: tb/sram_wr_seq_tb_top.sv
`timescale 1ns/1ps
module sram_wr_seq_tb_top;
    localparam int T_AS = 2, T_LEAD = 1, T_WP = 3, T_CW = 2, T_AW = 6;
    localparam int T_DW = 2, T_DH = 1, T_WR = 2, T_WHZ = 2;
    localparam logic [14:0] GHOST_ADDR = 15'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, mode = 1'b0, oel = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  data = '0;
    logic        busy, done, ce_n, we_n, oe_n, dq_oe;
    logic [14:0] s_addr;
    logic [7:0]  dq;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    sram_wr_seq #(
        .T_AS(T_AS), .T_LEAD(T_LEAD), .T_WP(T_WP), .T_CW(T_CW), .T_AW(T_AW),
        .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR), .T_WHZ(T_WHZ)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .oe_low_i(oel),
        .addr_i(addr), .data_i(data), .busy_o(busy), .done_o(done),
        .sram_addr_o(s_addr), .sram_ce_n_o(ce_n), .sram_we_n_o(we_n),
        .sram_oe_n_o(oe_n), .sram_dq_o(dq), .sram_dq_oe_o(dq_oe)
    );

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
        end
    endtask

    // Behavioural memory model, sampled on the falling edge
    logic [7:0] mem [int];
    logic        p_ce = 1'b1, p_we = 1'b1;
    logic [14:0] p_addr = '0;
    int  win_len = 0, drive_off = -1, hold_len = 0, done_cnt = 0;
    bit  in_hold = 0, ce_first = 0, we_first = 0, end_together = 0;
    logic [7:0]  w_dq = '0;
    logic [14:0] w_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (s_addr != p_addr)
                chk(ce_n && we_n && p_ce && p_we, "R3 addr moved under strobe", int'(s_addr), int'(p_addr));
            if (dq_oe && !ce_n && we_n && !oe_n)
                chk(1'b0, "R6 bus contention", 1, 0);
            if (done) done_cnt++;
            if (in_hold) begin
                if (dq_oe && ce_n && we_n) hold_len++;
                else in_hold = 0;
            end
            if (!ce_n && !we_n) begin
                if (p_ce || p_we) begin
                    win_len = 0; drive_off = -1;
                    ce_first = !p_ce; we_first = !p_we;
                end
                if (dq_oe && drive_off < 0) drive_off = win_len;
                win_len++;
                w_dq = dq; w_addr = s_addr;
            end else if (!p_ce && !p_we) begin
                mem[int'(w_addr)] = w_dq;
                end_together = ce_n && we_n;
                in_hold = 1; hold_len = 0;
                if (dq_oe && ce_n && we_n) hold_len = 1;
            end
            p_ce = ce_n; p_we = we_n; p_addr = s_addr;
        end
    end

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic do_write(input bit m, input bit ol, input logic [14:0] a,
                            input logic [7:0] d, input bit poke);
        int pb, pw, total, dcyc;
        bit seen;
        pb = mx(mx(T_WP, T_CW), mx(T_DW, T_AW - T_AS - T_LEAD));
        pw = (m == 1'b0 && ol) ? mx(pb, T_WHZ + T_DW + 1) : pb;
        total = T_AS + T_LEAD + pw + T_DH + T_WR;
        @(negedge clk);
        req = 1'b1; mode = m; oel = ol; addr = a; data = d;
        seen = 0; dcyc = -1;
        for (int k = 1; k <= total + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req = 1'b0; addr = ~a; data = ~d; mode = ~m; oel = ~ol;
            end
            if (poke && k == 3) begin req = 1'b1; addr = GHOST_ADDR; end
            if (poke && k == 4) req = 1'b0;
            if (k <= total) begin
                if (!busy) chk(1'b0, "R2 busy during sequence", 0, 1);
                if (oe_n != !ol) chk(1'b0, "R9 output enable level", int'(oe_n), int'(!ol));
                if (s_addr != a) chk(1'b0, "R7 address held", int'(s_addr), int'(a));
                if (done) chk(1'b0, "R8 early done", k, total + 1);
            end else begin
                chk(done && !busy, "R8 done due cycle", int'(done), 1);
                chk(oe_n, "R9 oe idle", int'(oe_n), 1);
            end
        end
        @(negedge clk);
        chk(!done, "R8 done single cycle", int'(done), 0);
        chk(win_len == pw, "R5 window length", win_len, pw);
        chk(m ? (we_first && !ce_first) : (ce_first && !we_first), "R4 strobe order",
            int'(ce_first), int'(!m));
        chk(end_together, "R4 strobes rise together", int'(end_together), 1);
        chk(drive_off == ((m == 1'b0 && ol) ? T_WHZ : 0), "R6 drive offset",
            drive_off, (m == 1'b0 && ol) ? T_WHZ : 0);
        chk(hold_len == T_DH, "R7 data hold", hold_len, T_DH);
        chk(mem.exists(int'(a)) && mem[int'(a)] == d, "R10 stored byte",
            mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, int'(d));
    endtask

    initial begin
        #(200000 * 8);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe && !busy && !done, "R1 state in reset",
            int'({ce_n, we_n, oe_n, dq_oe, busy, done}), 6'b111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ce_n && we_n && oe_n && !dq_oe && !busy && !done, "R1 state after reset",
            int'({ce_n, we_n, oe_n, dq_oe, busy, done}), 6'b111000);
        n = 0;
        for (int m = 0; m < 2; m++)
            for (int ol = 0; ol < 2; ol++)
                for (int i = 0; i < 6; i++) begin
                    logic [14:0] a;
                    a = (i == 0) ? 15'h0000 : (i == 5) ? 15'h7FFF : 15'((i * 5461 + m * 97 + ol * 13) & 32'h7FFF);
                    do_write(m[0], ol[0], a, 8'((n * 37 + 11) & 8'hFF), (i == 2));
                    n++;
                end
        chk(!mem.exists(int'(GHOST_ADDR)), "R2 request while busy ignored", 1, 0);
        chk(done_cnt == n, "R2 one done per accepted request", done_cnt, n);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule